// File: doc/BRIEF.md
# Operating-Mode Control Register Sequencer

This block holds the mode-control state of a processor core: a 64-bit extended-feature register with syscall, long-mode-enable, long-mode-active and no-execute bits; a system control word carrying protection-enable and paging-enable; a second control word carrying the address-extension enable; and a 64-bit root translation table base. Software reaches these registers one request at a time through an indexed port. The 64-bit values travel as two 32-bit halves, and each request carries the requester's privilege level.

The block works out the operating mode from the bits it holds: real, protected, or long mode active. It also enforces the order of transitions. Long-mode-active is never written directly. Hardware sets it when paging turns on while long-mode enable and address extension are both already set, and clears it when paging turns off. A write that breaks the entry or exit order is refused. A refused write changes no state and raises a one-cycle fault. Decoding the instructions that issue these requests, and loading segments, are handled elsewhere.

Top module: `mode_ctl_seq`

## Requirements
- R1: After reset, every held bit and the root base are 0, mode_o is 0 (real) and fault_o is 0.
- R2: The extended-feature register answers at index 0xC0000080. In its low half, bit 0 is syscall enable, bit 8 is long-mode enable, bit 10 is long-mode active and bit 11 is no-execute enable. All other bits read 0 and ignore writes. The control word at index 0x00000C00 has protection-enable at bit 0 and paging-enable at bit 31. The control word at index 0x00000C04 has address-extension enable at bit 5.
- R3: The root base register at index 0x00000C03 stores all 64 bits. On writes the low half comes from wr_lo_i and the high half from wr_hi_i. On reads the low half goes to rd_lo_o and the high half to rd_hi_o.
- R4: A request whose privilege level priv_i is not 0 faults and changes no state, whether it is a read or a write.
- R5: A request to any other index faults.
- R6: The long-mode-active bit is read-only. A value written to bit 10 has no effect.
- R7: Long-mode-active becomes 1 when paging goes from 0 to 1 while long-mode enable and address extension are both 1. It becomes 0 when paging is cleared.
- R8: A write that changes long-mode enable while paging is on faults. A write that keeps long-mode enable at its current value is accepted.
- R9: A write that would leave paging on with protection off faults. This covers setting paging without protection and clearing protection before paging.
- R10: Setting paging while long-mode enable is 1 and address extension is 0 faults.
- R11: Clearing address extension while long mode is active faults.
- R12: mode_o is 2 when long mode is active, otherwise 1 when protection is on, otherwise 0. It never shows 3.
- R13: fault_o is high for exactly the cycle after a faulting request. A read result appears on rd_lo_o/rd_hi_o one cycle after the request, and the outputs hold that value until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 2 | Privilege level of the requester |
| idx_i | input | 32 | Register index |
| wr_lo_i | input | 32 | Write data, low half |
| wr_hi_i | input | 32 | Write data, high half |
| rd_lo_o | output | 32 | Read data, low half |
| rd_hi_o | output | 32 | Read data, high half |
| fault_o | output | 1 | Previous request was refused |
| mode_o | output | 2 | 0 real, 1 protected, 2 long mode active |

## Verification
On every cycle, the assertions check several invariants. Long-mode-active never holds without paging, protection, long-mode enable and address extension all set. Paging never holds without protection. Long-mode enable stays fixed while paging is on. A request at a nonzero privilege level leaves all state untouched and raises a fault. The mode encoding never shows 3. Other properties need a sequence of writes and are shown only by the bench's scenarios: the full real-to-long entry and exit, rejection of each out-of-order write, the read-only active bit, the split of 64-bit data into halves, and the one-cycle width of the fault pulse.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  localparam int unsigned IDX_W  = 32;
  localparam int unsigned HALF_W = 32;

  localparam logic [IDX_W-1:0] IDX_FEAT = 32'hC000_0080;
  localparam logic [IDX_W-1:0] IDX_CTL0 = 32'h0000_0C00;
  localparam logic [IDX_W-1:0] IDX_ROOT = 32'h0000_0C03;
  localparam logic [IDX_W-1:0] IDX_CTL4 = 32'h0000_0C04;

  localparam int unsigned FEAT_SCE_BIT = 0;
  localparam int unsigned FEAT_LME_BIT = 8;
  localparam int unsigned FEAT_LMA_BIT = 10;
  localparam int unsigned FEAT_NXE_BIT = 11;
  localparam int unsigned CTL0_PE_BIT  = 0;
  localparam int unsigned CTL0_PG_BIT  = 31;
  localparam int unsigned CTL4_PAE_BIT = 5;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_FEAT, SEL_CTL0, SEL_ROOT, SEL_CTL4
  } sel_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_PROT = 2'd1,
    MODE_LONG = 2'd2
  } mode_e;

  // held mode-control bits
  typedef struct packed {
    logic sce;
    logic lme;
    logic lma;
    logic nxe;
    logic pe;
    logic pg;
    logic pae;
  } ctl_t;

  // writable bits extracted from write data
  typedef struct packed {
    logic sce;
    logic lme;
    logic nxe;
    logic pe;
    logic pg;
    logic pae;
  } wr_t;
endpackage

// File: rtl/mode_ctl_decode.sv
module mode_ctl_decode
  import mode_ctl_pkg::*;
#(
  parameter int unsigned IW = IDX_W
) (
  input  logic [IW-1:0] idx_i,
  output sel_e          sel_o
);
  always_comb begin
    unique case (idx_i)
      IDX_FEAT: sel_o = SEL_FEAT;
      IDX_CTL0: sel_o = SEL_CTL0;
      IDX_ROOT: sel_o = SEL_ROOT;
      IDX_CTL4: sel_o = SEL_CTL4;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/mode_ctl_check.sv
module mode_ctl_check
  import mode_ctl_pkg::*;
(
  input  sel_e       sel_i,
  input  logic       we_i,
  input  logic [1:0] priv_i,
  input  ctl_t       cur_i,
  input  wr_t        wr_i,
  output logic       fault_o,
  output logic       root_we_o,
  output ctl_t       nxt_o
);
  always_comb begin
    nxt_o     = cur_i;
    fault_o   = 1'b0;
    root_we_o = 1'b0;
    if (priv_i != 2'd0) begin
      fault_o = 1'b1;
    end else if (sel_i == SEL_NONE) begin
      fault_o = 1'b1;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_FEAT: begin
          if (cur_i.pg && (wr_i.lme != cur_i.lme)) begin
            fault_o = 1'b1;
          end else begin
            nxt_o.sce = wr_i.sce;
            nxt_o.lme = wr_i.lme;
            nxt_o.nxe = wr_i.nxe;
          end
        end
        SEL_CTL0: begin
          if (wr_i.pg && !wr_i.pe) begin
            fault_o = 1'b1;                       // paging needs protection
          end else if (wr_i.pg && !cur_i.pg && cur_i.lme && !cur_i.pae) begin
            fault_o = 1'b1;                       // extension must precede paging
          end else begin
            nxt_o.pe = wr_i.pe;
            nxt_o.pg = wr_i.pg;
            if (!wr_i.pg)
              nxt_o.lma = 1'b0;
            else if (!cur_i.pg)
              nxt_o.lma = cur_i.lme & cur_i.pae;
          end
        end
        SEL_CTL4: begin
          if (cur_i.lma && !wr_i.pae) fault_o = 1'b1;
          else                        nxt_o.pae = wr_i.pae;
        end
        SEL_ROOT: root_we_o = 1'b1;
        default:  fault_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/mode_ctl_regs.sv
module mode_ctl_regs
  import mode_ctl_pkg::*;
#(
  parameter int unsigned HW = HALF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    priv_i,
  input  sel_e          sel_i,
  input  logic          fault_i,
  input  logic          root_we_i,
  input  ctl_t          nxt_i,
  input  logic [HW-1:0] wr_lo_i,
  input  logic [HW-1:0] wr_hi_i,
  output ctl_t          ctl_o,
  output logic [HW-1:0] rd_lo_o,
  output logic [HW-1:0] rd_hi_o,
  output logic          fault_o
);
  localparam int unsigned DW = 2 * HW;

  ctl_t          ctl_q;
  logic [DW-1:0] root_q;
  logic [DW-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    unique case (sel_i)
      SEL_FEAT: begin
        rd_val[FEAT_SCE_BIT] = ctl_q.sce;
        rd_val[FEAT_LME_BIT] = ctl_q.lme;
        rd_val[FEAT_LMA_BIT] = ctl_q.lma;
        rd_val[FEAT_NXE_BIT] = ctl_q.nxe;
      end
      SEL_CTL0: begin
        rd_val[CTL0_PE_BIT] = ctl_q.pe;
        rd_val[CTL0_PG_BIT] = ctl_q.pg;
      end
      SEL_CTL4: rd_val[CTL4_PAE_BIT] = ctl_q.pae;
      SEL_ROOT: rd_val = root_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      root_q  <= '0;
      rd_lo_o <= '0;
      rd_hi_o <= '0;
      fault_o <= 1'b0;
    end else begin
      fault_o <= req_i & fault_i;
      if (req_i && !fault_i) begin
        if (we_i) begin
          ctl_q <= nxt_i;
          if (root_we_i) root_q <= {wr_hi_i, wr_lo_i};
        end else begin
          rd_lo_o <= rd_val[HW-1:0];
          rd_hi_o <= rd_val[DW-1:HW];
        end
      end
    end
  end

  assign ctl_o = ctl_q;

  p_lma_needs_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lma |-> (ctl_q.pg && ctl_q.pe && ctl_q.lme && ctl_q.pae));

  p_pg_needs_pe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.pg |-> ctl_q.pe);

  p_lme_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.pg |=> (ctl_q.lme == $past(ctl_q.lme)));

  p_priv_no_change_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && priv_i != 2'd0) |=> ($stable(ctl_q) && $stable(root_q) && fault_o));

  p_lma_falls_with_pg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_q.pg) |-> !ctl_q.lma);
endmodule

// File: rtl/mode_ctl_seq.sv
module mode_ctl_seq
  import mode_ctl_pkg::*;
#(
  parameter int unsigned IW = IDX_W,
  parameter int unsigned HW = HALF_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    priv_i,
  input  logic [IW-1:0] idx_i,
  input  logic [HW-1:0] wr_lo_i,
  input  logic [HW-1:0] wr_hi_i,
  output logic [HW-1:0] rd_lo_o,
  output logic [HW-1:0] rd_hi_o,
  output logic          fault_o,
  output logic [1:0]    mode_o
);
  sel_e sel;
  ctl_t ctl, nxt;
  wr_t  wr;
  logic chk_fault, root_we;

  assign wr.sce = wr_lo_i[FEAT_SCE_BIT];
  assign wr.lme = wr_lo_i[FEAT_LME_BIT];
  assign wr.nxe = wr_lo_i[FEAT_NXE_BIT];
  assign wr.pe  = wr_lo_i[CTL0_PE_BIT];
  assign wr.pg  = wr_lo_i[CTL0_PG_BIT];
  assign wr.pae = wr_lo_i[CTL4_PAE_BIT];

  mode_ctl_decode #(.IW(IW)) u_decode (
    .idx_i (idx_i),
    .sel_o (sel)
  );

  mode_ctl_check u_check (
    .sel_i     (sel),
    .we_i      (we_i),
    .priv_i    (priv_i),
    .cur_i     (ctl),
    .wr_i      (wr),
    .fault_o   (chk_fault),
    .root_we_o (root_we),
    .nxt_o     (nxt)
  );

  mode_ctl_regs #(.HW(HW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .priv_i    (priv_i),
    .sel_i     (sel),
    .fault_i   (chk_fault),
    .root_we_i (root_we),
    .nxt_i     (nxt),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .ctl_o     (ctl),
    .rd_lo_o   (rd_lo_o),
    .rd_hi_o   (rd_hi_o),
    .fault_o   (fault_o)
  );

  always_comb begin
    if (ctl.lma)     mode_o = MODE_LONG;
    else if (ctl.pe) mode_o = MODE_PROT;
    else             mode_o = MODE_REAL;
  end

  p_mode_legal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);

  p_fault_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !fault_o);
endmodule

// File: tb/mode_ctl_seq_tb.sv
module mode_ctl_seq_tb;
  localparam logic [31:0] FT = 32'hC000_0080;
  localparam logic [31:0] C0 = 32'h0000_0C00;
  localparam logic [31:0] RT = 32'h0000_0C03;
  localparam logic [31:0] C4 = 32'h0000_0C04;

  typedef struct packed {
    logic        we;
    logic [1:0]  cpl;
    logic [31:0] idx;
    logic [31:0] wlo;
    logic [31:0] whi;
    logic        flt;
    logic [31:0] elo;
    logic [31:0] ehi;
    logic [1:0]  emode;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, FT, 32'h0,         32'h0,  1'b0, 32'h0,         32'h0,  2'd0}, // 0  R2 reset value
    '{1'b1, 2'd0, FT, 32'hFFFF_FFFF, 32'hFF, 1'b0, 32'h0,         32'h0,  2'd0}, // 1  R2 R6 write all ones
    '{1'b0, 2'd0, FT, 32'h0,         32'h0,  1'b0, 32'h0000_0901, 32'h0,  2'd0}, // 2  R6 active bit ignored
    '{1'b1, 2'd0, C0, 32'h8000_0001, 32'h0,  1'b1, 32'h0,         32'h0,  2'd0}, // 3  R10 paging before ext
    '{1'b1, 2'd0, C4, 32'h0000_0020, 32'h0,  1'b0, 32'h0,         32'h0,  2'd0}, // 4  R2 ext on
    '{1'b1, 2'd0, RT, 32'h0012_3000, 32'hAB, 1'b0, 32'h0,         32'h0,  2'd0}, // 5  R3 root write
    '{1'b0, 2'd0, RT, 32'h0,         32'h0,  1'b0, 32'h0012_3000, 32'hAB, 2'd0}, // 6  R3 root halves
    '{1'b1, 2'd0, C0, 32'h8000_0000, 32'h0,  1'b1, 32'h0,         32'h0,  2'd0}, // 7  R9 paging w/o prot
    '{1'b1, 2'd0, C0, 32'h0000_0001, 32'h0,  1'b0, 32'h0,         32'h0,  2'd1}, // 8  R12 protected
    '{1'b1, 2'd0, C0, 32'h8000_0001, 32'h0,  1'b0, 32'h0,         32'h0,  2'd2}, // 9  R7 R12 long active
    '{1'b0, 2'd0, FT, 32'h0,         32'h0,  1'b0, 32'h0000_0D01, 32'h0,  2'd2}, // 10 R7 active bit set
    '{1'b1, 2'd0, FT, 32'h0000_0001, 32'h0,  1'b1, 32'h0,         32'h0,  2'd2}, // 11 R8 lme change
    '{1'b1, 2'd0, C4, 32'h0,         32'h0,  1'b1, 32'h0,         32'h0,  2'd2}, // 12 R11 ext clear
    '{1'b1, 2'd0, FT, 32'h0000_0100, 32'h0,  1'b0, 32'h0,         32'h0,  2'd2}, // 13 R8 lme kept
    '{1'b0, 2'd3, FT, 32'h0,         32'h0,  1'b1, 32'h0,         32'h0,  2'd2}, // 14 R4 read at level 3
    '{1'b1, 2'd1, C0, 32'h0,         32'h0,  1'b1, 32'h0,         32'h0,  2'd2}, // 15 R4 write at level 1
    '{1'b0, 2'd0, FT, 32'h0,         32'h0,  1'b0, 32'h0000_0500, 32'h0,  2'd2}, // 16 R4 state intact
    '{1'b1, 2'd0, C0, 32'h8000_0000, 32'h0,  1'b1, 32'h0,         32'h0,  2'd2}, // 17 R9 prot off first
    '{1'b1, 2'd0, C0, 32'h0000_0001, 32'h0,  1'b0, 32'h0,         32'h0,  2'd1}, // 18 R7 paging off
    '{1'b0, 2'd0, FT, 32'h0,         32'h0,  1'b0, 32'h0000_0100, 32'h0,  2'd1}, // 19 R7 active cleared
    '{1'b1, 2'd0, C0, 32'h0,         32'h0,  1'b0, 32'h0,         32'h0,  2'd0}, // 20 R12 real again
    '{1'b0, 2'd0, 32'h1234, 32'h0,   32'h0,  1'b1, 32'h0,         32'h0,  2'd0}, // 21 R5 bad index
    '{1'b0, 2'd0, C0, 32'h0,         32'h0,  1'b0, 32'h0,         32'h0,  2'd0}, // 22 R2 ctl0 read
    '{1'b0, 2'd0, C4, 32'h0,         32'h0,  1'b0, 32'h0000_0020, 32'h0,  2'd0}  // 23 R2 ctl4 read
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic [31:0] idx = '0, wlo = '0, whi = '0;
  logic [31:0] rd_lo, rd_hi;
  logic        fault;
  logic [1:0]  mode;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  mode_ctl_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .priv_i(priv),
    .idx_i(idx), .wr_lo_i(wlo), .wr_hi_i(whi), .rd_lo_o(rd_lo),
    .rd_hi_o(rd_hi), .fault_o(fault), .mode_o(mode)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input vec_t v);
    @(negedge clk);
    req = 1'b1; we = v.we; priv = v.cpl; idx = v.idx; wlo = v.wlo; whi = v.whi;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mode", 64'(mode), 64'd0);
    check("R1 fault", 64'(fault), 64'd0);
    check("R1 rdata", {rd_hi, rd_lo}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VECS[i]);
      check($sformatf("vec%0d fault", i), 64'(fault), 64'(VECS[i].flt));
      check($sformatf("vec%0d mode R12", i), 64'(mode), 64'(VECS[i].emode));
      if (!VECS[i].we && !VECS[i].flt)
        check($sformatf("vec%0d rdata R13", i), {rd_hi, rd_lo}, {VECS[i].ehi, VECS[i].elo});
    end

    // R13 fault lasts one cycle; read data held while idle
    access('{1'b0, 2'd2, FT, 32'h0, 32'h0, 1'b1, 32'h0, 32'h0, 2'd0});
    check("R13 fault raised", 64'(fault), 64'd1);
    check("R13 rdata held", {rd_hi, rd_lo}, 64'h20);
    @(negedge clk);
    check("R13 fault one cycle", 64'(fault), 64'd0);

    // enter long mode again, then reset mid-flight: R1
    access('{1'b1, 2'd0, FT, 32'h100, 32'h0, 1'b0, 32'h0, 32'h0, 2'd0});
    access('{1'b1, 2'd0, C4, 32'h20,  32'h0, 1'b0, 32'h0, 32'h0, 2'd0});
    access('{1'b1, 2'd0, C0, 32'h1,   32'h0, 1'b0, 32'h0, 32'h0, 2'd1});
    access('{1'b1, 2'd0, C0, 32'h8000_0001, 32'h0, 1'b0, 32'h0, 32'h0, 2'd2});
    check("R7 reentry mode", 64'(mode), 64'd2);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mode after reset", 64'(mode), 64'd0);
    rst_n = 1'b1;
    access('{1'b0, 2'd0, FT, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 2'd0});
    check("R1 feature after reset", {rd_hi, rd_lo}, 64'd0);
    access('{1'b0, 2'd0, RT, 32'h0, 32'h0, 1'b0, 32'h0, 32'h0, 2'd0});
    check("R1 root after reset", {rd_hi, rd_lo}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule